// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block orders the stop and restart of the output clock groups of a multi-output clock generator. An active-low power-down request is filtered in the CPU-domain clock. When it is accepted, the groups are parked one after another, each only on a falling edge of its own clock. Once every group is confirmed parked, the oscillator and PLL enables are dropped.

When the request is withdrawn, the oscillator and PLLs are enabled again and no group runs until the lock-detect input is high. The CPU group and buffered output 1 then restart together, so that an external DLL fed from buffered output 1 can settle first. A holdoff counted in reference-clock ticks follows. After it, buffered outputs 0 and 2, then PCI, then the 48 MHz and REF groups are released. If the request returns during the restart, the block turns straight back into the stop sequence, keeping whatever is already parked.

The group clocks enter as sampled levels in the CPU-domain clock, which must be fast enough to see every phase of them. The outputs are one run enable per group, a park flag for the differential CPU drivers, the oscillator and PLL enables, and a busy flag with a state code.

Top module: `clk_pd_seq`

## Requirements
- R1: The internal power-down request sets only after `pd_n_i` is sampled low on two consecutive rising edges, and clears only after it is sampled high on two consecutive edges. When `pd_n_i` is first sampled low at edge k and is still low at edge k+1, `busy_o` rises after edge k+2. A single low sample has no effect.
- R2: Group bit positions in `grp_clk_i`/`grp_run_o` are: 0 PCI, 1 buffered outputs 0 and 2, 2 buffered output 1, 3 CPU and driven 3V66, 4 48 MHz, 5 REF. On entry, groups park in this order: PCI, then bits 1 and 2 together on the same edge, then CPU, then 48 MHz, then REF. `osc_en_o` and `pll_en_o` fall only after REF is confirmed parked.
- R3: A group's run enable falls only at an edge where its clock is sampled low after being sampled high on the edge before. It rises only at an edge where its clock is sampled low, so no output pulse is ever shortened.
- R4: `cpu_park_o` is 1 exactly while the CPU group is held, which means the true side is driven high at twice the reference current and the complement side is left floating.
- R5: No group runs while `osc_en_o` is low. After the enables return, no group runs until `lock_i` has been seen high.
- R6: After lock, the CPU group and buffered output 1 are released first, while all other groups stay held.
- R7: Buffered outputs 0 and 2 are released no earlier than HOLD_TICKS pulses of `ref_tick_i` after both early groups run. HOLD_TICKS divided by the reference rate REF_KHZ must lie between 30 µs and 400 µs, otherwise elaboration stops.
- R8: After the holdoff, the release order is buffered outputs 0 and 2, then PCI, then 48 MHz and REF.
- R9: A power-down request accepted at any point of the restart leads to the stop sequence. Groups that never restarted stay held, and the running ones park in the R2 order until the enables fall.
- R10: After reset, all groups are held, `osc_en_o` and `pll_en_o` are 1, `busy_o` is 1, and `state_o` is 7 (waiting for lock).
- R11: `busy_o` is 0 and `state_o` is 0 only when every group runs. In the off state `state_o` is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_n_i | input | 1 | Active-low power-down request |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| lock_i | input | 1 | PLL lock detect |
| grp_clk_i | input | 6 | Sampled level of each group clock |
| grp_run_o | output | 6 | Run enable per group (1 = running) |
| cpu_park_o | output | 1 | Differential CPU pair parked true-high |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| busy_o | output | 1 | Sequencer outside the running state |
| state_o | output | 4 | Sequencer state code |

## Verification
The assertions take four things for granted. Each group clock is stable between edges of `clk_i` and toggles slowly enough that every high and low phase is sampled at least once. `lock_i` stays high from its rise until the enables drop. `ref_tick_i` is a single-cycle pulse. The stimulus derives every group clock and the tick from one counter, updated a short delay after each rising edge, with every group clock period at least four system cycles. It drives `pd_n_i` and `lock_i` only on falling edges, lowering lock only once the off state is reached.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
  localparam int NGRP = 6;
  localparam int G_PCI = 0;
  localparam int G_B02 = 1;
  localparam int G_B1  = 2;
  localparam int G_CPU = 3;
  localparam int G_48  = 4;
  localparam int G_REF = 5;

  typedef enum logic [3:0] {
    S_RUN      = 4'd0,
    S_STP_PCI  = 4'd1,
    S_STP_BUF  = 4'd2,
    S_STP_CPU  = 4'd3,
    S_STP_48   = 4'd4,
    S_STP_REF  = 4'd5,
    S_OFF      = 4'd6,
    S_LOCK     = 4'd7,
    S_REL_CPU  = 4'd8,
    S_HOLD     = 4'd9,
    S_REL_BUF  = 4'd10,
    S_REL_PCI  = 4'd11,
    S_REL_SLOW = 4'd12
  } seq_e;

  // groups newly parked on entering a state
  function automatic logic [NGRP-1:0] park_bits(seq_e s);
    logic [NGRP-1:0] b;
    b = '0;
    case (s)
      S_STP_PCI: b[G_PCI] = 1'b1;
      S_STP_BUF: begin b[G_B02] = 1'b1; b[G_B1] = 1'b1; end
      S_STP_CPU: b[G_CPU] = 1'b1;
      S_STP_48:  b[G_48]  = 1'b1;
      S_STP_REF: b[G_REF] = 1'b1;
      default:   b = '0;
    endcase
    return b;
  endfunction

  // groups newly released on entering a state
  function automatic logic [NGRP-1:0] free_bits(seq_e s);
    logic [NGRP-1:0] b;
    b = '0;
    case (s)
      S_REL_CPU:  begin b[G_CPU] = 1'b1; b[G_B1] = 1'b1; end
      S_REL_BUF:  b[G_B02] = 1'b1;
      S_REL_PCI:  b[G_PCI] = 1'b1;
      S_REL_SLOW: begin b[G_48] = 1'b1; b[G_REF] = 1'b1; end
      default:    b = '0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/clkpd_filt.sv
module clkpd_filt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_n_i,
  output logic pd_o
);
  logic smp_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b1;
      pd_q  <= 1'b0;
    end else begin
      smp_q <= pd_n_i;
      if (!pd_n_i && !smp_q)     pd_q <= 1'b1;
      else if (pd_n_i && smp_q)  pd_q <= 1'b0;
    end
  end

  assign pd_o = pd_q;

  a_r1_enter_two_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> (!$past(pd_n_i) && !$past(pd_n_i, 2)));
  a_r1_exit_two_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_q) |-> ($past(pd_n_i) && $past(pd_n_i, 2)));
endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gclk_i,
  input  logic park_i,
  output logic run_o
);
  logic gclk_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gclk_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      gclk_q <= gclk_i;
      // park on a falling edge, resume only in the low phase
      if (run_q && park_i && gclk_q && !gclk_i)  run_q <= 1'b0;
      else if (!run_q && !park_i && !gclk_i)     run_q <= 1'b1;
    end
  end

  assign run_o = run_q;

  a_r3_park_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> ($past(gclk_q) && !$past(gclk_i)));
  a_r3_resume_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !$past(gclk_i));
endmodule

// File: rtl/clkpd_hold.sv
module clkpd_hold #(
  parameter int TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r7_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> (cnt_q == $past(cnt_q)) || !$past(en_i));
endmodule

// File: rtl/clk_pd_seq.sv
module clk_pd_seq
  import clkpd_pkg::*;
#(
  parameter int HOLD_TICKS = 1000,
  parameter int REF_KHZ    = 14318
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pd_n_i,
  input  logic            ref_tick_i,
  input  logic            lock_i,
  input  logic [NGRP-1:0] grp_clk_i,
  output logic [NGRP-1:0] grp_run_o,
  output logic            cpu_park_o,
  output logic            osc_en_o,
  output logic            pll_en_o,
  output logic            busy_o,
  output logic [3:0]      state_o
);
  // holdoff window 30..400 us, in units of ticks*1000/kHz
  localparam longint HOLD_NUM = longint'(HOLD_TICKS) * 1000;
  localparam bit HOLD_OK = (HOLD_NUM > 30 * longint'(REF_KHZ)) &&
                           (HOLD_NUM < 400 * longint'(REF_KHZ));

  if (!HOLD_OK) begin : g_bad_holdoff
    initial $fatal(1, "holdoff outside 30..400 us");
  end

  seq_e            state_q, state_n;
  logic [NGRP-1:0] park_q, park_n;
  logic [NGRP-1:0] run;
  logic            pd, hold_done, settled;

  clkpd_filt u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_n_i (pd_n_i),
    .pd_o   (pd)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_gate
    clkpd_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gclk_i (grp_clk_i[g]),
      .park_i (park_q[g]),
      .run_o  (run[g])
    );
  end

  clkpd_hold #(.TICKS(HOLD_TICKS)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_HOLD),
    .tick_i (ref_tick_i),
    .done_o (hold_done)
  );

  // every gate has reached what is requested of it
  assign settled = (run == ~park_q);

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_RUN:      if (pd) state_n = S_STP_PCI;
      S_STP_PCI:  if (settled) state_n = S_STP_BUF;
      S_STP_BUF:  if (settled) state_n = S_STP_CPU;
      S_STP_CPU:  if (settled) state_n = S_STP_48;
      S_STP_48:   if (settled) state_n = S_STP_REF;
      S_STP_REF:  if (settled) state_n = S_OFF;
      S_OFF:      if (!pd) state_n = S_LOCK;
      S_LOCK:     if (pd) state_n = S_STP_PCI;
                  else if (lock_i) state_n = S_REL_CPU;
      S_REL_CPU:  if (pd) state_n = S_STP_PCI;
                  else if (settled) state_n = S_HOLD;
      S_HOLD:     if (pd) state_n = S_STP_PCI;
                  else if (hold_done) state_n = S_REL_BUF;
      S_REL_BUF:  if (pd) state_n = S_STP_PCI;
                  else if (settled) state_n = S_REL_PCI;
      S_REL_PCI:  if (pd) state_n = S_STP_PCI;
                  else if (settled) state_n = S_REL_SLOW;
      S_REL_SLOW: if (pd) state_n = S_STP_PCI;
                  else if (settled) state_n = S_RUN;
      default:    state_n = S_LOCK;
    endcase
    // park requests are sticky across an abort
    park_n = (park_q | park_bits(state_n)) & ~free_bits(state_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_LOCK;
      park_q  <= '1;
    end else begin
      state_q <= state_n;
      park_q  <= park_n;
    end
  end

  assign grp_run_o  = run;
  assign cpu_park_o = ~run[G_CPU];
  assign osc_en_o   = (state_q != S_OFF);
  assign pll_en_o   = (state_q != S_OFF);
  assign busy_o     = (state_q != S_RUN);
  assign state_o    = state_q;

  a_r5_dark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (grp_run_o == '0));
  a_r6_cpu_from_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grp_run_o[G_CPU]) |-> ($past(state_q) == S_REL_CPU));
  a_r6_early_pair_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_run_o[G_B02] |-> (grp_run_o[G_B1] && grp_run_o[G_CPU]));
  a_r8_pci_after_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_run_o[G_PCI] |-> grp_run_o[G_B02]);
  a_r11_idle_all_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((&grp_run_o) && osc_en_o));
endmodule

// File: tb/clk_pd_seq_tb.sv
module clk_pd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int HOLD_TICKS = 1000;
  localparam int WD_LIMIT   = 150000;
  localparam int PCI = 0, B02 = 1, B1 = 2, CPU = 3, F48 = 4, REF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_n = 1'b1;
  logic       ref_tick = 1'b0;
  logic       lock = 1'b0;
  logic [5:0] gclk = '0;
  logic [5:0] run;
  logic       cpu_park, osc_en, pll_en, busy;
  logic [3:0] state;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int gcnt = 0;
  logic [5:0] seen_now = '0, seen_m1 = '0;
  int fall_t [6];
  int rise_t [6];
  int off_t = -1;
  int lock_t = -1;
  logic [5:0] run_prev = '0;
  logic osc_prev = 1'b1;

  clk_pd_seq #(.HOLD_TICKS(HOLD_TICKS), .REF_KHZ(14318)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pd_n_i     (pd_n),
    .ref_tick_i (ref_tick),
    .lock_i     (lock),
    .grp_clk_i  (gclk),
    .grp_run_o  (run),
    .cpu_park_o (cpu_park),
    .osc_en_o   (osc_en),
    .pll_en_o   (pll_en),
    .busy_o     (busy),
    .state_o    (state)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] gen_clk(input int c);
    logic [5:0] v;
    v[PCI] = c[3];
    v[B02] = c[2];
    v[B1]  = c[2];
    v[CPU] = c[1];
    v[F48] = c[2];
    v[REF] = c[4];
    return v;
  endfunction

  // group clocks and tick move shortly after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    seen_m1  = seen_now;
    seen_now = gclk;
    cyc++;
    gcnt++;
    gclk     = gen_clk(gcnt);
    ref_tick = (gcnt % TICK_DIV == 0);
  end

  // event monitor at falling edges
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      for (int g = 0; g < 6; g++) begin
        if (run_prev[g] && !run[g]) begin
          fall_t[g] = cyc;
          chk(seen_now[g] == 1'b0 && seen_m1[g] == 1'b1, "R3 park edge",
              {seen_m1[g], seen_now[g]}, 2);
        end
        if (!run_prev[g] && run[g]) begin
          rise_t[g] = cyc;
          chk(seen_now[g] == 1'b0, "R3 resume low", seen_now[g], 0);
          chk(lock == 1'b1, "R5 run only after lock", lock, 1);
        end
      end
      if (osc_prev && !osc_en) off_t = cyc;
      if (!osc_en) chk(run == '0, "R5 dark while off", run, 0);
      chk(cpu_park == !run[CPU], "R4 cpu park", cpu_park, !run[CPU]);
      chk(pll_en == osc_en, "R5 pll follows osc", pll_en, osc_en);
    end
    run_prev = run;
    osc_prev = osc_en;
  end

  task automatic clr_times();
    for (int g = 0; g < 6; g++) begin
      fall_t[g] = -1;
      rise_t[g] = -1;
    end
    off_t = -1;
  endtask

  task automatic check_entry_order();
    chk(fall_t[PCI] > 0 && fall_t[PCI] < fall_t[B02], "R2 pci first", fall_t[PCI], fall_t[B02]);
    chk(fall_t[B02] == fall_t[B1], "R2 buffers together", fall_t[B02], fall_t[B1]);
    chk(fall_t[B1] < fall_t[CPU], "R2 cpu after buffers", fall_t[CPU], fall_t[B1]);
    chk(fall_t[CPU] < fall_t[F48], "R2 48 after cpu", fall_t[F48], fall_t[CPU]);
    chk(fall_t[F48] < fall_t[REF], "R2 ref after 48", fall_t[REF], fall_t[F48]);
    chk(fall_t[REF] < off_t, "R2 osc off last", off_t, fall_t[REF]);
    chk(state == 4'd6, "R11 off state code", state, 6);
  endtask

  task automatic power_down();
    clr_times();
    @(negedge clk) pd_n = 1'b0;
    while (osc_en) @(negedge clk);
    @(negedge clk) lock = 1'b0;
  endtask

  task automatic release_seq(input int lock_dly);
    int early;
    clr_times();
    while (!osc_en) @(negedge clk);
    chk(run == '0, "R5 held before lock", run, 0);
    repeat (lock_dly) @(negedge clk);
    chk(run == '0, "R5 held until lock", run, 0);
    lock = 1'b1;
    lock_t = cyc;
    while (busy) @(negedge clk);
    early = (rise_t[CPU] > rise_t[B1]) ? rise_t[CPU] : rise_t[B1];
    chk(rise_t[CPU] >= lock_t && rise_t[B1] >= lock_t, "R6 early pair after lock",
        rise_t[CPU], lock_t);
    chk(rise_t[B02] > early && rise_t[PCI] > early && rise_t[F48] > early &&
        rise_t[REF] > early, "R6 others held", rise_t[B02], early);
    chk(rise_t[B02] - early >= (HOLD_TICKS - 1) * TICK_DIV, "R7 holdoff min",
        rise_t[B02] - early, (HOLD_TICKS - 1) * TICK_DIV);
    chk(rise_t[B02] - early <= HOLD_TICKS * TICK_DIV + 48, "R7 holdoff max",
        rise_t[B02] - early, HOLD_TICKS * TICK_DIV + 48);
    chk(rise_t[PCI] > rise_t[B02], "R8 pci after buffers", rise_t[PCI], rise_t[B02]);
    chk(rise_t[F48] > rise_t[PCI] && rise_t[REF] > rise_t[PCI], "R8 48 and ref last",
        rise_t[F48], rise_t[PCI]);
    chk(run == 6'h3f && state == 4'd0, "R11 idle running", {state, run}, 8'h3f);
  endtask

  initial begin
    clr_times();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(run == '0, "R10 groups held", run, 0);
    chk(osc_en && pll_en, "R10 enables on", {osc_en, pll_en}, 3);
    chk(busy == 1'b1 && state == 4'd7, "R10 busy lock-wait", {busy, state}, 5'h17);
    chk(cpu_park == 1'b1, "R10 R4 cpu parked", cpu_park, 1);
    release_seq(20);

    // R1 single low sample ignored
    @(negedge clk) pd_n = 1'b0;
    @(negedge clk) pd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && run == 6'h3f, "R1 glitch ignored", busy, 0);

    // R1 exact latency, then R2 order
    clr_times();
    @(negedge clk) pd_n = 1'b0;
    @(negedge clk) chk(busy == 1'b0, "R1 after first low", busy, 0);
    @(negedge clk) chk(busy == 1'b0, "R1 after second low", busy, 0);
    @(negedge clk) chk(busy == 1'b1, "R1 busy rises", busy, 1);
    while (osc_en) @(negedge clk);
    check_entry_order();
    @(negedge clk) lock = 1'b0;

    // R1 single high sample in off state ignored
    @(negedge clk) pd_n = 1'b1;
    @(negedge clk) pd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(state == 4'd6 && !osc_en, "R1 release glitch ignored", state, 6);
    @(negedge clk) pd_n = 1'b1;
    release_seq(3);

    // sweep of lock delays over full cycles
    for (int k = 0; k < 3; k++) begin
      power_down();
      check_entry_order();
      @(negedge clk) pd_n = 1'b1;
      release_seq(k * 7);
    end

    // R9 abort during holdoff
    power_down();
    @(negedge clk) pd_n = 1'b1;
    clr_times();
    while (!osc_en) @(negedge clk);
    lock = 1'b1;
    while (state != 4'd9) @(negedge clk);
    repeat (10) @(negedge clk);
    pd_n = 1'b0;
    while (osc_en) @(negedge clk);
    chk(rise_t[B02] == -1 && rise_t[PCI] == -1 && rise_t[REF] == -1,
        "R9 late groups never ran", rise_t[B02], -1);
    chk(fall_t[B1] > 0 && fall_t[B1] < fall_t[CPU], "R9 buffer parks before cpu",
        fall_t[B1], fall_t[CPU]);
    chk(fall_t[CPU] < off_t, "R9 off after cpu", off_t, fall_t[CPU]);
    @(negedge clk) lock = 1'b0;
    @(negedge clk) pd_n = 1'b1;
    release_seq(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= WD_LIMIT);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule